// File: doc/BRIEF.md
# Shadow Remote-Cache Coherence Directory

This block is the home node's record of which remote caches hold its memory lines. It keeps one shadow tag array per remote cache. Each shadow has the same number of sets and ways as the cache it mirrors, and it records only the lines whose home is this node. A line address presented on the lookup port is checked against every shadow at once. The hits are gathered into a presence vector with one bit per remote cache, plus a flag that says whether any holder has the line modified.

A single update port carries the traffic that keeps each shadow exact. That traffic is fills (clean or modified), a mark-modified notice and eviction notices, each tagged with the remote cache it concerns. An entry leaves a shadow only when its remote cache reports the eviction. A fill into a set therefore always finds a free way in a consistent system. A fill that finds its set full is reported on an error flag and changes nothing.

Addresses carry a home-node field in their top bits. The field's value is compared with a parameter. Traffic for any other home is ignored, and lookups of such lines report no holders.

Top module: `shadow_dir`

## Requirements
- R1: After reset no shadow holds an entry: every lookup returns an all-zero presence vector and a clear modified flag, and `rsp_valid` stays low until a lookup is made.
- R2: A fill with `upd_op`=2'b00 (clean) for cache c makes later lookups of that line report presence bit c set and the modified flag clear. A lookup accepted in cycle t is answered in cycle t+1 with `rsp_valid` high, and `rsp_valid` is low in any cycle that follows a cycle with no lookup.
- R3: A fill with `upd_op`=2'b01 (modified) records the line as modified. The lookup's modified flag is the OR of the modified state over every cache that holds the line.
- R4: `upd_op`=2'b10 marks a line that the named cache already holds as modified. For a line that the cache does not hold, it has no effect.
- R5: `upd_op`=2'b11 (evict) removes the line from the named cache's shadow only. Other caches holding the same line keep their presence and modified state.
- R6: The presence vector has bit c set exactly when shadow c holds the line, so several holders show as several bits.
- R7: A fill that finds every way of its set occupied and no match raises `err_full` for one cycle, in the cycle after the update, and stores nothing. After one way of that set is evicted, the same fill succeeds without error.
- R8: A fill for a line the cache already holds reuses its way, sets the modified state from the fill kind and allocates no second way.
- R9: An update whose address home field (the top `HOME_W` bits) differs from `HOME_ID`, or whose cache number is `NUM_SHADOW` or more, changes no state and never raises `err_full`. A lookup of a line of another home returns no holders.
- R10: When a lookup and an update reach the same line in one cycle, the lookup returns the state from before the update.
- R11: Shadow sets are independent: the set index comes from the address bits just above the 6-bit line offset, and a line filled in one set does not hit a lookup in another set with the same tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; clears all presence state |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_addr | input | PADDR_W | Physical address of the line to look up |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after `lk_valid`) |
| rsp_present | output | NUM_SHADOW | One bit per remote cache holding the line |
| rsp_modified | output | 1 | Some holder has the line modified |
| upd_valid | input | 1 | Update request this cycle |
| upd_op | input | 2 | 00 fill clean, 01 fill modified, 10 mark modified, 11 evict |
| upd_cache | input | CID_W | Remote cache the update concerns |
| upd_addr | input | PADDR_W | Physical address of the updated line |
| err_full | output | 1 | A fill found its set full in the previous cycle |

## Verification
A lookup and an update can target the same line in the same cycle. The bench provokes this by raising `lk_valid` and `upd_valid` together on one address, once with a fill and once with an evict. The answer must show the line's state from before the update: absent for the fill, present for the evict. A plain lookup in the next cycle must then show the updated state, which proves that the update was applied and not lost.

// File: rtl/shdir_pkg.sv
package shdir_pkg;

    // Update operations carried on the update port
    typedef enum logic [1:0] {
        OP_FILL_CLEAN = 2'b00,
        OP_FILL_DIRTY = 2'b01,
        OP_MARK_DIRTY = 2'b10,
        OP_EVICT      = 2'b11
    } upd_op_e;

endpackage

// File: rtl/shadow_bank.sv
module shadow_bank
    import shdir_pkg::*;
#(
    parameter int SETS  = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 27,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic             rd_mod,
    input  logic             wr_en,
    input  upd_op_e          wr_op,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic             wr_full
);

    typedef struct {
        logic [WAYS-1:0]  p   [SETS];
        logic [WAYS-1:0]  m   [SETS];
        logic [TAG_W-1:0] tag [SETS][WAYS];
    } bank_t;

    bank_t st_d, st_q;

    logic [WAYS-1:0] rd_vec;
    logic [WAYS-1:0] wr_vec;
    logic [WAYS-1:0] free_vec;
    logic [WAYS-1:0] slot_vec;
    logic            slot_found;
    logic            fill_dirty;

    always_comb begin
        st_d       = st_q;
        wr_full    = 1'b0;
        rd_vec     = '0;
        wr_vec     = '0;
        slot_vec   = '0;
        slot_found = 1'b0;
        fill_dirty = (wr_op == OP_FILL_DIRTY);

        for (int w = 0; w < WAYS; w++) begin
            rd_vec[w] = st_q.p[rd_idx][w] && (st_q.tag[rd_idx][w] == rd_tag);
            wr_vec[w] = st_q.p[wr_idx][w] && (st_q.tag[wr_idx][w] == wr_tag);
        end
        rd_hit = |rd_vec;
        rd_mod = |(rd_vec & st_q.m[rd_idx]);

        // lowest free way of the written set
        free_vec = ~st_q.p[wr_idx];
        for (int w = 0; w < WAYS; w++) begin
            if (free_vec[w] && !slot_found) begin
                slot_vec[w] = 1'b1;
                slot_found  = 1'b1;
            end
        end

        if (wr_en) begin
            unique case (wr_op)
                OP_FILL_CLEAN, OP_FILL_DIRTY: begin
                    if (|wr_vec) begin
                        st_d.m[wr_idx] = fill_dirty ? (st_q.m[wr_idx] | wr_vec)
                                                    : (st_q.m[wr_idx] & ~wr_vec);
                    end else if (slot_found) begin
                        st_d.p[wr_idx] = st_q.p[wr_idx] | slot_vec;
                        st_d.m[wr_idx] = fill_dirty ? (st_q.m[wr_idx] | slot_vec)
                                                    : (st_q.m[wr_idx] & ~slot_vec);
                        for (int w = 0; w < WAYS; w++) begin
                            if (slot_vec[w]) st_d.tag[wr_idx][w] = wr_tag;
                        end
                    end else begin
                        wr_full = 1'b1;
                    end
                end
                OP_MARK_DIRTY: st_d.m[wr_idx] = st_q.m[wr_idx] | wr_vec;
                OP_EVICT: begin
                    st_d.p[wr_idx] = st_q.p[wr_idx] & ~wr_vec;
                    st_d.m[wr_idx] = st_q.m[wr_idx] & ~wr_vec;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) st_q.p[s] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8
    wr_match_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $onehot0(wr_vec));

    // R7
    full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_full |-> (st_q.p[wr_idx] == {WAYS{1'b1}}) && (wr_vec == '0));

endmodule

// File: rtl/shadow_dir.sv
module shadow_dir
    import shdir_pkg::*;
#(
    parameter int NUM_SHADOW = 7,
    parameter int SETS       = 16,
    parameter int WAYS       = 4,
    parameter int PADDR_W    = 40,
    parameter int OFF_W      = 6,
    parameter int HOME_W     = 3,
    parameter int HOME_ID    = 0,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = PADDR_W - OFF_W - IDX_W - HOME_W,
    localparam int CID_W = (NUM_SHADOW > 1) ? $clog2(NUM_SHADOW) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lk_valid,
    input  logic [PADDR_W-1:0]    lk_addr,
    output logic                  rsp_valid,
    output logic [NUM_SHADOW-1:0] rsp_present,
    output logic                  rsp_modified,
    input  logic                  upd_valid,
    input  logic [1:0]            upd_op,
    input  logic [CID_W-1:0]      upd_cache,
    input  logic [PADDR_W-1:0]    upd_addr,
    output logic                  err_full
);

    typedef struct packed {
        logic                  vld;
        logic [NUM_SHADOW-1:0] pres;
        logic                  mod;
        logic                  err;
    } out_t;

    out_t out_d, out_q;

    logic [IDX_W-1:0]      lk_idx, up_idx;
    logic [TAG_W-1:0]      lk_tag, up_tag;
    logic                  lk_home, up_home;
    logic [NUM_SHADOW-1:0] hit_vec, mod_vec, full_vec;
    upd_op_e               op;

    assign lk_idx  = lk_addr[OFF_W +: IDX_W];
    assign lk_tag  = lk_addr[OFF_W+IDX_W +: TAG_W];
    assign lk_home = (lk_addr[PADDR_W-1 -: HOME_W] == HOME_W'(HOME_ID));
    assign up_idx  = upd_addr[OFF_W +: IDX_W];
    assign up_tag  = upd_addr[OFF_W+IDX_W +: TAG_W];
    assign up_home = (upd_addr[PADDR_W-1 -: HOME_W] == HOME_W'(HOME_ID));
    assign op      = upd_op_e'(upd_op);

    for (genvar c = 0; c < NUM_SHADOW; c++) begin : g_shadow
        shadow_bank #(
            .SETS  (SETS),
            .WAYS  (WAYS),
            .TAG_W (TAG_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (lk_idx),
            .rd_tag  (lk_tag),
            .rd_hit  (hit_vec[c]),
            .rd_mod  (mod_vec[c]),
            .wr_en   (upd_valid && up_home && (upd_cache == CID_W'(c))),
            .wr_op   (op),
            .wr_idx  (up_idx),
            .wr_tag  (up_tag),
            .wr_full (full_vec[c])
        );
    end

    always_comb begin
        out_d      = '0;
        out_d.vld  = lk_valid;
        out_d.err  = |full_vec;
        if (lk_valid && lk_home) begin
            out_d.pres = hit_vec;
            out_d.mod  = |mod_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid    = out_q.vld;
    assign rsp_present  = out_q.pres;
    assign rsp_modified = out_q.mod;
    assign err_full     = out_q.err;

    // R2
    rsp_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(lk_valid));

    // R3
    mod_needs_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_modified |-> (rsp_present != '0));

    // R7
    err_from_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_full |-> $past(upd_valid && !upd_op[1]));

    // R9
    err_home_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_full |-> $past(upd_addr[PADDR_W-1 -: HOME_W] == HOME_W'(HOME_ID)));

endmodule

// File: tb/shadow_dir_tb.sv
module shadow_dir_tb;

    localparam int NS    = 7;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int PW    = 40;
    localparam int IDX_W = 2;
    localparam int TAG_W = PW - 6 - IDX_W - 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0;
    logic [PW-1:0] lk_addr = '0;
    logic          rsp_valid;
    logic [NS-1:0] rsp_present;
    logic          rsp_modified;
    logic          upd_valid = 1'b0;
    logic [1:0]    upd_op = 2'b00;
    logic [2:0]    upd_cache = '0;
    logic [PW-1:0] upd_addr = '0;
    logic          err_full;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    shadow_dir #(.NUM_SHADOW(NS), .SETS(SETS), .WAYS(WAYS), .PADDR_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rsp_valid(rsp_valid), .rsp_present(rsp_present), .rsp_modified(rsp_modified),
        .upd_valid(upd_valid), .upd_op(upd_op), .upd_cache(upd_cache),
        .upd_addr(upd_addr), .err_full(err_full));

    function automatic logic [PW-1:0] mk(input int home, input int tag, input int idx);
        return {3'(home), TAG_W'(tag), IDX_W'(idx), 6'b0};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // one update; err_full is checked in the following cycle
    task automatic upd(input int cid, input logic [1:0] op, input logic [PW-1:0] a,
                       input logic exp_err, input string req);
        @(negedge clk);
        upd_valid = 1'b1; upd_op = op; upd_cache = 3'(cid); upd_addr = a;
        @(negedge clk);
        upd_valid = 1'b0;
        check(req, 32'(err_full), 32'(exp_err));
    endtask

    task automatic look(input logic [PW-1:0] a, input logic [NS-1:0] ep,
                        input logic em, input string req);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, 32'(rsp_valid), 32'd1);
        check(req, 32'(rsp_present), 32'(ep));
        check(req, 32'(rsp_modified), 32'(em));
    endtask

    task automatic t_reset();
        check("R1", 32'(rsp_valid), 32'd0);
        look(mk(0, 1, 0), '0, 1'b0, "R1");
        look(mk(0, 0, 3), '0, 1'b0, "R1");
    endtask

    task automatic t_fill();
        upd(2, 2'b00, mk(0, 1, 0), 1'b0, "R2");
        look(mk(0, 1, 0), 7'b0000100, 1'b0, "R2");
        @(negedge clk);
        check("R2", 32'(rsp_valid), 32'd0);
        upd(5, 2'b01, mk(0, 1, 0), 1'b0, "R3");
        look(mk(0, 1, 0), 7'b0100100, 1'b1, "R3 R6");
    endtask

    task automatic t_mark_evict();
        upd(2, 2'b10, mk(0, 2, 0), 1'b0, "R4");
        look(mk(0, 2, 0), '0, 1'b0, "R4");
        upd(2, 2'b10, mk(0, 1, 0), 1'b0, "R4");
        upd(5, 2'b11, mk(0, 1, 0), 1'b0, "R5");
        look(mk(0, 1, 0), 7'b0000100, 1'b1, "R4 R5");
        upd(2, 2'b11, mk(0, 1, 0), 1'b0, "R5");
        look(mk(0, 1, 0), '0, 1'b0, "R5");
    endtask

    task automatic t_full();
        for (int t = 10; t < 14; t++) upd(0, 2'b00, mk(0, t, 1), 1'b0, "R7");
        upd(0, 2'b00, mk(0, 14, 1), 1'b1, "R7");
        @(negedge clk);
        check("R7", 32'(err_full), 32'd0);
        look(mk(0, 14, 1), '0, 1'b0, "R7");
        look(mk(0, 10, 1), 7'b0000001, 1'b0, "R7");
        upd(0, 2'b11, mk(0, 11, 1), 1'b0, "R7");
        upd(0, 2'b01, mk(0, 14, 1), 1'b0, "R7");
        look(mk(0, 14, 1), 7'b0000001, 1'b1, "R7");
    endtask

    task automatic t_refill();
        upd(1, 2'b00, mk(0, 20, 2), 1'b0, "R8");
        upd(1, 2'b01, mk(0, 20, 2), 1'b0, "R8");
        for (int t = 21; t < 24; t++) upd(1, 2'b00, mk(0, t, 2), 1'b0, "R8");
        look(mk(0, 20, 2), 7'b0000010, 1'b1, "R8");
        upd(1, 2'b00, mk(0, 20, 2), 1'b0, "R8");
        look(mk(0, 20, 2), 7'b0000010, 1'b0, "R8");
    endtask

    task automatic t_foreign();
        upd(3, 2'b00, mk(1, 30, 0), 1'b0, "R9");
        look(mk(1, 30, 0), '0, 1'b0, "R9");
        look(mk(0, 30, 0), '0, 1'b0, "R9");
        upd(0, 2'b00, mk(2, 50, 1), 1'b0, "R9");
        upd(7, 2'b00, mk(0, 31, 0), 1'b0, "R9");
        look(mk(0, 31, 0), '0, 1'b0, "R9");
        upd(3, 2'b00, mk(0, 30, 0), 1'b0, "R9");
        upd(3, 2'b11, mk(4, 30, 0), 1'b0, "R9");
        look(mk(0, 30, 0), 7'b0001000, 1'b0, "R9");
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = mk(0, 40, 3);
        upd_valid = 1'b1; upd_op = 2'b00; upd_cache = 3'd4; upd_addr = mk(0, 40, 3);
        @(negedge clk);
        lk_valid = 1'b0; upd_valid = 1'b0;
        check("R10", 32'(rsp_present), 32'd0);
        look(mk(0, 40, 3), 7'b0010000, 1'b0, "R10");
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = mk(0, 40, 3);
        upd_valid = 1'b1; upd_op = 2'b11; upd_cache = 3'd4; upd_addr = mk(0, 40, 3);
        @(negedge clk);
        lk_valid = 1'b0; upd_valid = 1'b0;
        check("R10", 32'(rsp_present), 32'b0010000);
        look(mk(0, 40, 3), '0, 1'b0, "R10");
    endtask

    task automatic t_sets();
        upd(6, 2'b00, mk(0, 60, 0), 1'b0, "R11");
        look(mk(0, 60, 1), '0, 1'b0, "R11");
        look(mk(0, 60, 0), 7'b1000000, 1'b0, "R11");
        upd(3, 2'b00, mk(0, 60, 0), 1'b0, "R6");
        look(mk(0, 60, 0), 7'b1001000, 1'b0, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_mark_evict();
        t_full();
        t_refill();
        t_foreign();
        t_same_cycle();
        t_sets();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule